// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block collects a vector of level-sensitive interrupt lines and drives two request outputs toward a processor: a normal request and a fast request. Each output has its own enable mask, and both masks share one vector of raw line levels. An output is high while at least one line that is both active and enabled in that output's mask is present. Each mask is changed only through a set port and a clear port. Writing a 1 to a bit of the set port enables that line. Writing a 1 to a bit of the clear port disables it. A 0 leaves the bit as it is, so two software agents can each change their own bits without a read-modify-write race.

Software reaches the block over a simple word-addressed register bus with separate read and write strobes. Software can read the raw levels, the masked status of each output and both masks. It can also drive line 0 active or inactive as a software interrupt. The software value is ORed with the external line 0, so either source can hold the line active. The bus carries no data stream. It has no valid/ready handshake and never applies back-pressure: a write is taken on the clock edge at which its strobe is high, and read data is valid combinationally in the same cycle as the read strobe. Only one access is possible per cycle.

Top module: `dual_req_intc`

## Requirements
- R1: After reset both masks and the software line-0 bit are zero, so both request outputs are low and words 2, 10 and 4 read zero.
- R2: Words 1 and 9 both read the level vector. Bit i is external line i, except bit 0, which is external line 0 ORed with the software line-0 bit.
- R3: After each clock edge, norm_req equals the OR-reduction of (level vector AND normal mask), and fast_req does the same with the fast mask. Both are evaluated from the line inputs, writes and state present before that edge, so an output follows a line change or a write one clock later.
- R4: A write to word 2 ORs bus_wdata into the normal mask. A write to word 3 clears each normal mask bit that is 1 in bus_wdata. Word 2 reads back the normal mask.
- R5: Words 10 (set) and 11 (clear) act on the fast mask in the same way, and word 10 reads it back. The two masks never affect each other.
- R6: Word 0 reads (level AND normal mask) and word 8 reads (level AND fast mask).
- R7: A write to word 4 with bus_wdata bit 0 = 1 sets the software line-0 bit, and a write to word 5 with bit 0 = 1 clears it. With bit 0 = 0, either write does nothing. Word 4 reads the level vector's bit 0 in bit 0, with all other bits zero.
- R8: Reads of words 3, 5 and 11 and of any unmapped word (6, 7 and 12 to 15) return zero.
- R9: Writes to words 0, 1, 8 and 9 and to unmapped words change neither mask nor the software bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_lines | input | 32 | Level-sensitive interrupt inputs |
| bus_addr | input | 4 | Word address |
| bus_wr | input | 1 | Write strobe, taken at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational, zero when bus_rd is low |
| norm_req | output | 1 | Normal interrupt request, registered |
| fast_req | output | 1 | Fast interrupt request, registered |

## Verification
A wrong mask bit shows at the ports in two places. It shows on the next read of words 2, 10, 0 or 8. It shows on a request output at the first edge where the matching line is active. The bench compares every cycle's request outputs and every read with a model, so a fault appears within one cycle of the first stimulus that exposes it. A stuck or wrongly ORed software bit shows on word 4 and words 1 and 9 while external line 0 is held low. The directed cases force exactly that condition.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int N_PATHS    = 2;
  localparam int PATH_NORM  = 0;
  localparam int PATH_FAST  = 1;
  localparam int WD_NSTAT   = 0;
  localparam int WD_NRAW    = 1;
  localparam int WD_NEN_SET = 2;
  localparam int WD_NEN_CLR = 3;
  localparam int WD_SW_SET  = 4;
  localparam int WD_SW_CLR  = 5;
  localparam int WD_FSTAT   = 8;
  localparam int WD_FRAW    = 9;
  localparam int WD_FEN_SET = 10;
  localparam int WD_FEN_CLR = 11;
endpackage

// File: rtl/intc_mask_reg.sv
module intc_mask_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] mask_n
);
  // clear takes priority over set for the same bit
  always_comb mask_n = (mask_q | set_vec) & ~clr_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_n;
  end

  // R4
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |=> ((mask_q & $past(clr_vec)) == '0));

  // R4
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec == '0) |=> ((mask_q & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/intc_decode.sv
module intc_decode
  import intc_pkg::*;
#(
  parameter int W      = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      level,
  input  logic [W-1:0]      mask_norm,
  input  logic [W-1:0]      mask_fast,
  output logic [W-1:0]      set_norm,
  output logic [W-1:0]      clr_norm,
  output logic [W-1:0]      set_fast,
  output logic [W-1:0]      clr_fast,
  output logic              sw_set,
  output logic              sw_clr,
  output logic [W-1:0]      rdata
);
  logic [31:0] word;
  always_comb word = 32'(addr);

  always_comb begin
    set_norm = '0;
    clr_norm = '0;
    set_fast = '0;
    clr_fast = '0;
    sw_set   = 1'b0;
    sw_clr   = 1'b0;
    if (wr) begin
      case (word)
        WD_NEN_SET: set_norm = wdata;
        WD_NEN_CLR: clr_norm = wdata;
        WD_FEN_SET: set_fast = wdata;
        WD_FEN_CLR: clr_fast = wdata;
        WD_SW_SET:  sw_set   = wdata[0];
        WD_SW_CLR:  sw_clr   = wdata[0];
        default:    ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      case (word)
        WD_NSTAT:   rdata = level & mask_norm;
        WD_NRAW:    rdata = level;
        WD_NEN_SET: rdata = mask_norm;
        WD_SW_SET:  rdata = {{(W-1){1'b0}}, level[0]};
        WD_FSTAT:   rdata = level & mask_fast;
        WD_FRAW:    rdata = level;
        WD_FEN_SET: rdata = mask_fast;
        default:    rdata = '0;
      endcase
    end
  end

  // R8
  clr_word_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (word == WD_NEN_CLR || word == WD_SW_CLR || word == WD_FEN_CLR))
      |-> (rdata == '0));
endmodule

// File: rtl/intc_req_reg.sv
module intc_req_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level_n,
  input  logic [W-1:0] mask_n,
  output logic         req_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= |(level_n & mask_n);
  end
endmodule

// File: rtl/dual_req_intc.sv
module dual_req_intc
  import intc_pkg::*;
#(
  parameter int N_LINES = 32,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_lines,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [N_LINES-1:0] bus_wdata,
  input  logic               bus_rd,
  output logic [N_LINES-1:0] bus_rdata,
  output logic               norm_req,
  output logic               fast_req
);
  localparam int W = N_LINES;

  logic [W-1:0] set_v  [N_PATHS];
  logic [W-1:0] clr_v  [N_PATHS];
  logic [W-1:0] mask_q [N_PATHS];
  logic [W-1:0] mask_n [N_PATHS];
  logic [N_PATHS-1:0] req_q;
  logic sw_set, sw_clr;
  logic soft_q, soft_n;
  logic [W-1:0] level_q, level_n;

  always_comb soft_n = (soft_q | sw_set) & ~sw_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) soft_q <= 1'b0;
    else        soft_q <= soft_n;
  end

  if (W > 1) begin : g_lvl_wide
    always_comb level_q = {irq_lines[W-1:1], irq_lines[0] | soft_q};
    always_comb level_n = {irq_lines[W-1:1], irq_lines[0] | soft_n};
  end else begin : g_lvl_one
    always_comb level_q = irq_lines | soft_q;
    always_comb level_n = irq_lines | soft_n;
  end

  intc_decode #(.W(W), .ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_n),
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .wdata(bus_wdata),
    .level(level_q),
    .mask_norm(mask_q[PATH_NORM]), .mask_fast(mask_q[PATH_FAST]),
    .set_norm(set_v[PATH_NORM]), .clr_norm(clr_v[PATH_NORM]),
    .set_fast(set_v[PATH_FAST]), .clr_fast(clr_v[PATH_FAST]),
    .sw_set(sw_set), .sw_clr(sw_clr),
    .rdata(bus_rdata)
  );

  for (genvar p = 0; p < N_PATHS; p++) begin : g_path
    intc_mask_reg #(.W(W)) u_mask (
      .clk(clk), .rst_n(rst_n),
      .set_vec(set_v[p]), .clr_vec(clr_v[p]),
      .mask_q(mask_q[p]), .mask_n(mask_n[p])
    );
    intc_req_reg #(.W(W)) u_req (
      .clk(clk), .rst_n(rst_n),
      .level_n(level_n), .mask_n(mask_n[p]),
      .req_q(req_q[p])
    );
  end

  always_comb norm_req = req_q[PATH_NORM];
  always_comb fast_req = req_q[PATH_FAST];

  // R3
  norm_req_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    norm_req |-> (mask_q[PATH_NORM] != '0));

  // R3
  fast_req_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fast_req |-> (mask_q[PATH_FAST] != '0));

  // R9
  ro_write_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (32'(bus_addr) == WD_NSTAT || 32'(bus_addr) == WD_NRAW ||
                32'(bus_addr) == WD_FSTAT || 32'(bus_addr) == WD_FRAW))
      |=> ($stable(mask_q[PATH_NORM]) && $stable(mask_q[PATH_FAST]) && $stable(soft_q)));
endmodule

// File: tb/dual_req_intc_test.sv
`timescale 1ns/1ps
module dual_req_intc_test;
  localparam int N  = 32;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq_lines = '0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [N-1:0]  bus_wdata = '0;
  logic          bus_rd = 1'b0;
  logic [N-1:0]  bus_rdata;
  logic          norm_req, fast_req;

  int checks = 0;
  int errors = 0;

  logic [N-1:0] m_norm = '0, m_fast = '0;
  logic         m_soft = 1'b0;
  logic         e_norm = 1'b0, e_fast = 1'b0;

  always #10 clk = ~clk;

  dual_req_intc #(.N_LINES(N), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .norm_req(norm_req), .fast_req(fast_req)
  );

  function automatic logic [N-1:0] lvl(input logic [N-1:0] ln, input logic s);
    lvl = ln;
    lvl[0] = ln[0] | s;
  endfunction

  function automatic logic [N-1:0] exp_read(input int w, input logic [N-1:0] ln);
    logic [N-1:0] l;
    l = lvl(ln, m_soft);
    case (w)
      0:  exp_read = l & m_norm;
      1:  exp_read = l;
      2:  exp_read = m_norm;
      4:  exp_read = {{(N-1){1'b0}}, l[0]};
      8:  exp_read = l & m_fast;
      9:  exp_read = l;
      10: exp_read = m_fast;
      default: exp_read = '0;
    endcase
  endfunction

  function automatic string rtag(input int w);
    case (w)
      0, 8:  rtag = "R6";
      1, 9:  rtag = "R2";
      2:     rtag = "R4";
      10:    rtag = "R5";
      4:     rtag = "R7";
      default: rtag = "R8";
    endcase
  endfunction

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // One bus cycle: check outputs, drive, check read data, clock, update model.
  task automatic cyc(input logic [N-1:0] ln, input logic wr, input logic rd,
                     input int w, input logic [N-1:0] wd);
    @(negedge clk);
    check("R3 norm_req", {{(N-1){1'b0}}, norm_req}, {{(N-1){1'b0}}, e_norm});
    check("R3 fast_req", {{(N-1){1'b0}}, fast_req}, {{(N-1){1'b0}}, e_fast});
    irq_lines = ln; bus_wr = wr; bus_rd = rd; bus_addr = AW'(w); bus_wdata = wd;
    #2;
    if (rd) check(rtag(w), bus_rdata, exp_read(w, ln));
    @(posedge clk);
    if (wr) begin
      case (w)
        2:  m_norm = m_norm | wd;
        3:  m_norm = m_norm & ~wd;
        10: m_fast = m_fast | wd;
        11: m_fast = m_fast & ~wd;
        4:  if (wd[0]) m_soft = 1'b1;
        5:  if (wd[0]) m_soft = 1'b0;
        default: ;
      endcase
    end
    e_norm = |(lvl(ln, m_soft) & m_norm);
    e_fast = |(lvl(ln, m_soft) & m_fast);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int seed;
    seed = 1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    check("R1 norm_req", {{(N-1){1'b0}}, norm_req}, '0);
    check("R1 fast_req", {{(N-1){1'b0}}, fast_req}, '0);
    cyc('1, 1'b0, 1'b1, 2, '0);
    cyc('1, 1'b0, 1'b1, 10, '0);
    cyc('0, 1'b0, 1'b1, 4, '0);

    // R7 software line 0 ORed with external line 0
    cyc('0, 1'b1, 1'b0, 2, 32'h1);
    cyc('0, 1'b1, 1'b0, 4, 32'hFFFF_FFFE);   // bit 0 clear: no effect
    cyc('0, 1'b0, 1'b1, 4, '0);
    cyc('0, 1'b1, 1'b0, 4, 32'h1);
    cyc('0, 1'b0, 1'b1, 4, '0);
    cyc('0, 1'b0, 1'b1, 1, '0);
    cyc(32'h1, 1'b1, 1'b0, 5, 32'h1);
    cyc(32'h1, 1'b0, 1'b1, 9, '0);
    cyc('0, 1'b0, 1'b1, 4, '0);

    // R9 writes to read-only and unmapped words
    cyc(32'hA5A5_0000, 1'b1, 1'b0, 10, 32'h00FF_00FF);
    foreach (m_norm[i]) if (i < 0) ;
    for (int w = 0; w < 16; w++)
      if (w inside {0, 1, 8, 9, 6, 7, 12, 13, 14, 15})
        cyc(32'hA5A5_0000, 1'b1, 1'b0, w, '1);
    cyc(32'hA5A5_0000, 1'b0, 1'b1, 2, '0);
    cyc(32'hA5A5_0000, 1'b0, 1'b1, 10, '0);
    cyc(32'hA5A5_0000, 1'b0, 1'b1, 4, '0);

    // R8 clear and unmapped words read zero
    for (int w = 0; w < 16; w++)
      if (w inside {3, 5, 11, 6, 7, 12, 13, 14, 15})
        cyc('1, 1'b0, 1'b1, w, '0);

    // R4 R5 clear paths, independent masks
    cyc(32'h8000_0000, 1'b1, 1'b0, 2, 32'h8000_0000);
    cyc(32'h8000_0000, 1'b1, 1'b0, 11, 32'hFFFF_FFFF);
    cyc(32'h8000_0000, 1'b1, 1'b0, 3, 32'h8000_0000);
    cyc(32'h8000_0000, 1'b0, 1'b1, 0, '0);

    // constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] ln, wd;
      int w;
      logic wr, rd;
      ln = $urandom() & $urandom();
      wd = ($urandom() % 4 == 0) ? 32'($urandom() % 2) : $urandom() & $urandom();
      w  = int'($urandom() % 16);
      wr = ($urandom() % 3 == 0);
      rd = !wr && ($urandom() % 2 == 0);
      cyc(ln, wr, rd, w, wd);
    end
    cyc('0, 1'b0, 1'b0, 0, '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule